// File: doc/BRIEF.md
# Three-Level Prioritized Interrupt Controller

This block collects interrupt requests for a small 8-bit processor. Each peripheral source signals an event with a single-cycle pulse. The controller stores that pulse in a sticky pending bit, ranks every pending source by a programmable two-bit level, and presents one winner to the processor as a request flag and a source index. When the processor accepts the request, the controller clears the pending bit of the winner and drops the global master enable. Software restores the master enable with an enable command, with a return-from-interrupt command, or by writing the control register.

A single register write port loads the pending register, the packed level codes and the control register. Some sources always rank at the top level, whatever code they hold. These are the oscillator-fail sources, chosen by a parameter mask, and the watchdog source while its top-level input is high. Any trap input, a disable command, a control write of 0 or an acknowledge turns the master enable off.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `irq_valid` is 0, every pending bit is clear, every level code is 00 and the master enable is 0.
- R2: A one-cycle pulse on `src_pulse[i]` sets pending bit i, and the bit stays set until an acknowledge or a software write clears it.
- R3: Level codes are packed in the level register with source i at bits [2i+1:2i]. Code 00 keeps the source out of arbitration. Codes 01, 10 and 11 give levels 1, 2 and 3.
- R4: A pending source at a higher level always wins over a pending source at a lower level.
- R5: Among pending sources at the same level, the lowest source index wins.
- R6: Sources in `TOP_MASK` compete at level 3 whatever their code, including code 00. While `wdt_top_en` is 1, the same holds for source `WDT_IDX`.
- R7: An `irq_ack` while `irq_valid` is 1 clears the pending bit of `irq_id` and the master enable. An `irq_ack` while `irq_valid` is 0 has no effect.
- R8: A write to address 0 loads the pending register from `wr_data[NSRC-1:0]`. Address 1 loads the level codes and address 2 loads the control register, whose bit 0 is the master enable. Address 3 is ignored.
- R9: A source pulse in the same cycle as a pending-register write, or as an acknowledge of that source, leaves the bit set.
- R10: The master enable is set by `cmd_ei`, by `cmd_iret`, or by a control write with bit 0 = 1.
- R11: The master enable is cleared by `cmd_di`, by any bit of `trap_in`, or by a control write with bit 0 = 0. Any clear event beats any set event in the same cycle.
- R12: `irq_valid` and `irq_id` are registered from the state after the same clock edge. `irq_valid` is 1 exactly when the master enable is 1 and at least one source takes part in arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | NSRC | Single-cycle request pulses, one per source |
| wdt_top_en | input | 1 | Forces source WDT_IDX to level 3 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 pending, 1 levels, 2 control |
| wr_data | input | 2*NSRC | Write data |
| cmd_ei | input | 1 | Enable-interrupts command |
| cmd_di | input | 1 | Disable-interrupts command |
| cmd_iret | input | 1 | Return-from-interrupt command |
| trap_in | input | NTRAP | Trap events that clear the master enable |
| irq_ack | input | 1 | Processor accepts the presented request |
| irq_valid | output | 1 | A request is presented |
| irq_id | output | IDW | Index of the winning source |

## Verification
The outputs are registered from next-state values. Any corruption of a pending bit, a level code or the master enable therefore appears at `irq_valid` or `irq_id` right after the clock edge that produced it. For example, a lost pulse removes a source from the winner order, and a stuck enable keeps presenting a request after an acknowledge or a trap. Both show on the very next sample. A full sweep of all pending patterns under several level layouts, with and without the forced watchdog source, compares every winner with an arithmetic model. Directed sequences then cover same-cycle collisions between pulses, writes, acknowledges and enable events.

// File: rtl/prio_irq_pkg.sv
// Shared definitions of the prioritized interrupt controller.
// Assumes level codes are two bits wide and ordered numerically.
package prio_irq_pkg;

    typedef enum logic [1:0] {
        LVL_OFF = 2'b00,
        LVL_LOW = 2'b01,
        LVL_MID = 2'b10,
        LVL_TOP = 2'b11
    } lvl_e;

    typedef enum logic [1:0] {
        RA_PEND = 2'd0,
        RA_PRIO = 2'd1,
        RA_CTRL = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    localparam int CTRL_EN_BIT = 0;

endpackage

// File: rtl/irq_req_latch.sv
// Sticky pending register: holds single-cycle source pulses.
// Assumes ack_id < NSRC whenever ack_clr is 1.
// Precedence inside one cycle: software load, then acknowledge clear, then pulse set.
module irq_req_latch #(
    parameter int NSRC = 8,
    parameter int IDW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_pulse,
    input  logic            wr_load,
    input  logic [NSRC-1:0] wr_val,
    input  logic            ack_clr,
    input  logic [IDW-1:0]  ack_id,
    output logic [NSRC-1:0] req_d
);

    logic [NSRC-1:0] req_q;
    logic [NSRC-1:0] clr_mask;

    // Decode the acknowledged index into a one-hot clear mask.
    always_comb begin
        clr_mask = '0;
        if (ack_clr) begin
            clr_mask = {{(NSRC-1){1'b0}}, 1'b1} << ack_id;
        end
    end

    // Form the next pending value; a pulse always survives.
    always_comb begin
        req_d = req_q;
        if (wr_load) begin
            req_d = wr_val;
        end
        req_d = (req_d & ~clr_mask) | src_pulse;
    end

    // Pending register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

endmodule

// File: rtl/irq_prio_regs.sv
// Per-source level code storage and effective level mapping.
// Assumes wr_val packs source i at bits [2i+1:2i].
// Forced sources report level 3 regardless of their stored code.
module irq_prio_regs #(
    parameter int NSRC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_load,
    input  logic [2*NSRC-1:0]    wr_val,
    input  logic [NSRC-1:0]      force_mask,
    output logic [NSRC-1:0][1:0] lvl_d
);

    import prio_irq_pkg::*;

    logic [NSRC-1:0][1:0] code_q;
    logic [NSRC-1:0][1:0] code_d;

    // Next stored codes: the write replaces all codes at once.
    always_comb begin
        code_d = code_q;
        if (wr_load) begin
            code_d = wr_val;
        end
    end

    // Level code register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    // Effective level per source.
    for (genvar g = 0; g < NSRC; g++) begin : g_lvl
        // Override to the top level for forced sources.
        always_comb begin
            lvl_d[g] = force_mask[g] ? LVL_TOP : code_d[g];
        end
    end

endmodule

// File: rtl/irq_master_en.sv
// Global master enable flag.
// Assumes set and clear events are already merged; clear dominates.
module irq_master_en (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic en_d
);

    logic en_q;

    // Next enable value with clear taking precedence.
    always_comb begin
        if (clr_ev) begin
            en_d = 1'b0;
        end else if (set_ev) begin
            en_d = 1'b1;
        end else begin
            en_d = en_q;
        end
    end

    // Enable flag with synchronous reset to disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
// Combinational winner selection: highest level, then lowest index.
// Assumes level 0 means not participating.
module irq_arbiter #(
    parameter int NSRC = 8,
    parameter int IDW  = 3
) (
    input  logic [NSRC-1:0]      req,
    input  logic [NSRC-1:0][1:0] lvl,
    output logic                 hit,
    output logic [IDW-1:0]       win_id
);

    logic [NSRC-1:0][1:0] cand_lvl;

    // Mask levels of sources that are not pending.
    for (genvar g = 0; g < NSRC; g++) begin : g_cand
        // Pending sources keep their level, others drop to zero.
        always_comb begin
            cand_lvl[g] = req[g] ? lvl[g] : 2'b00;
        end
    end

    // Scan upward; only a strictly higher level replaces the best.
    always_comb begin
        logic [1:0] best;
        best   = 2'b00;
        win_id = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand_lvl[i] > best) begin
                best   = cand_lvl[i];
                win_id = IDW'(i);
            end
        end
        hit = (best != 2'b00);
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Three-level prioritized interrupt controller, top level.
// Assumes single-cycle source pulses and one acknowledge per presented request.
// Outputs are registered from next-state values, so they track state with no extra lag.
module prio_irq_ctrl #(
    parameter int              NSRC     = 8,
    parameter int              NTRAP    = 4,
    parameter int              WDT_IDX  = NSRC - 2,
    parameter logic [NSRC-1:0] TOP_MASK = {1'b1, {(NSRC-1){1'b0}}},
    localparam int             IDW      = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int             DW       = 2 * NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_pulse,
    input  logic             wdt_top_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             cmd_ei,
    input  logic             cmd_di,
    input  logic             cmd_iret,
    input  logic [NTRAP-1:0] trap_in,
    input  logic             irq_ack,
    output logic             irq_valid,
    output logic [IDW-1:0]   irq_id
);

    import prio_irq_pkg::*;

    logic                 wr_pend;
    logic                 wr_prio;
    logic                 wr_ctrl;
    logic                 ack_eff;
    logic                 set_ev;
    logic                 clr_ev;
    logic [NSRC-1:0]      force_mask;
    logic [NSRC-1:0]      req_d;
    logic [NSRC-1:0][1:0] lvl_d;
    logic                 en_d;
    logic                 hit;
    logic [IDW-1:0]       win_id;

    // Decode register writes.
    always_comb begin
        wr_pend = wr_en && (wr_addr == RA_PEND);
        wr_prio = wr_en && (wr_addr == RA_PRIO);
        wr_ctrl = wr_en && (wr_addr == RA_CTRL);
    end

    // Acknowledge counts only while a request is presented.
    always_comb begin
        ack_eff = irq_ack && irq_valid;
    end

    // Merge master enable events.
    always_comb begin
        set_ev = cmd_ei || cmd_iret || (wr_ctrl && wr_data[CTRL_EN_BIT]);
        clr_ev = cmd_di || ack_eff || (|trap_in)
              || (wr_ctrl && !wr_data[CTRL_EN_BIT]);
    end

    // Sources forced to the top level.
    always_comb begin
        force_mask = TOP_MASK;
        if (wdt_top_en) begin
            force_mask[WDT_IDX] = 1'b1;
        end
    end

    irq_req_latch #(
        .NSRC (NSRC),
        .IDW  (IDW)
    ) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .wr_load   (wr_pend),
        .wr_val    (wr_data[NSRC-1:0]),
        .ack_clr   (ack_eff),
        .ack_id    (irq_id),
        .req_d     (req_d)
    );

    irq_prio_regs #(
        .NSRC (NSRC)
    ) u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_load    (wr_prio),
        .wr_val     (wr_data),
        .force_mask (force_mask),
        .lvl_d      (lvl_d)
    );

    irq_master_en u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_ev),
        .clr_ev (clr_ev),
        .en_d   (en_d)
    );

    irq_arbiter #(
        .NSRC (NSRC),
        .IDW  (IDW)
    ) u_arb (
        .req    (req_d),
        .lvl    (lvl_d),
        .hit    (hit),
        .win_id (win_id)
    );

    // Register the presented request from post-edge state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_id    <= '0;
        end else begin
            irq_valid <= en_d && hit;
            irq_id    <= hit ? win_id : '0;
        end
    end

endmodule

// File: rtl/prio_irq_chk.sv
// Port-level properties of the interrupt controller, bound to the top module.
// Assumes the default port widths of the bound instance.
module prio_irq_chk #(
    parameter int NSRC  = 8,
    parameter int NTRAP = 4,
    parameter int IDW   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_di,
    input logic [NTRAP-1:0] trap_in,
    input logic             irq_ack,
    input logic             irq_valid,
    input logic [IDW-1:0]   irq_id
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !irq_valid);

    // R7
    ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_valid) |=> !irq_valid);

    // R11
    trap_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|trap_in) |=> !irq_valid);

    // R11
    di_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_di |=> !irq_valid);

    // R12
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (int'(irq_id) < NSRC));

endmodule

bind prio_irq_ctrl prio_irq_chk #(
    .NSRC  (NSRC),
    .NTRAP (NTRAP),
    .IDW   (IDW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_di    (cmd_di),
    .trap_in   (trap_in),
    .irq_ack   (irq_ack),
    .irq_valid (irq_valid),
    .irq_id    (irq_id)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns / 100ps
module test_prio_irq_ctrl;

    localparam int NSRC  = 8;
    localparam int NTRAP = 4;
    localparam int IDW   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src_pulse = '0;
    logic             wdt_top_en = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [2*NSRC-1:0] wr_data = '0;
    logic             cmd_ei = 1'b0;
    logic             cmd_di = 1'b0;
    logic             cmd_iret = 1'b0;
    logic [NTRAP-1:0] trap_in = '0;
    logic             irq_ack = 1'b0;
    logic             irq_valid;
    logic [IDW-1:0]   irq_id;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_pulse  (src_pulse),
        .wdt_top_en (wdt_top_en),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cmd_ei     (cmd_ei),
        .cmd_di     (cmd_di),
        .cmd_iret   (cmd_iret),
        .trap_in    (trap_in),
        .irq_ack    (irq_ack),
        .irq_valid  (irq_valid),
        .irq_id     (irq_id)
    );

    // Encoded output: 0 when idle, 16 + id when valid.
    function automatic int outv();
        return irq_valid ? (16 + int'(irq_id)) : 0;
    endfunction

    // Expected winner with master enable on: highest level, then lowest index.
    function automatic int model(input logic [NSRC-1:0] req,
                                 input logic [2*NSRC-1:0] codes,
                                 input bit wdt);
        int best = 0;
        int id = 0;
        for (int i = 0; i < NSRC; i++) begin
            int lv;
            lv = codes[2*i +: 2];
            if (i == NSRC - 1 || (wdt && i == NSRC - 2)) lv = 3;
            if (req[i] && lv > best) begin
                best = lv;
                id = i;
            end
        end
        return (best != 0) ? (16 + id) : 0;
    endfunction

    function automatic logic [2*NSRC-1:0] layout(input int cfg);
        logic [2*NSRC-1:0] w;
        for (int i = 0; i < NSRC; i++) begin
            w[2*i +: 2] = 2'((i * (cfg + 1) + cfg) % 4);
        end
        return w;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock edge passes; inputs return to idle at the next falling edge.
    task automatic tick();
        @(negedge clk);
        src_pulse = '0;
        wr_en = 1'b0;
        cmd_ei = 1'b0;
        cmd_di = 1'b0;
        cmd_iret = 1'b0;
        trap_in = '0;
        irq_ack = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [2*NSRC-1:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle under reset
        check("R1 reset valid", outv(), 0);
        rst_n = 1'b1;
        tick();
        // R1: codes cleared, so only forced source 7 competes
        wr(2'd2, 16'h0001); tick();
        wr(2'd0, 16'h00ff); tick();
        check("R1 codes cleared", outv(), 16 + 7);
        // R6: watchdog forcing adds source 6 at level 3
        wdt_top_en = 1'b1; tick();
        check("R6 wdt forced", outv(), 16 + 6);
        wdt_top_en = 1'b0; tick();
        check("R6 wdt released", outv(), 16 + 7);

        // R3 R4 R5 R6: exhaustive pending sweep across level layouts
        for (int w = 0; w < 2; w++) begin
            wdt_top_en = w[0];
            for (int cfg = 0; cfg < 4; cfg++) begin
                wr(2'd1, layout(cfg)); tick();
                for (int r = 0; r < 256; r++) begin
                    wr(2'd0, 16'(r)); tick();
                    check("R3/R4/R5/R6 sweep", outv(), model(8'(r), layout(cfg), w[0]));
                end
            end
        end
        wdt_top_en = 1'b0;

        wr(2'd1, 16'h5555); tick();
        wr(2'd0, 16'h0000); tick();
        check("R8 cleared", outv(), 0);
        // R2: pulse is latched and stays
        src_pulse = 8'h08; tick();
        check("R2 latch", outv(), 16 + 3);
        tick(); tick(); tick();
        check("R2 sticky", outv(), 16 + 3);
        // R7: acknowledge clears bit and enable
        irq_ack = 1'b1; tick();
        check("R7 ack off", outv(), 0);
        cmd_ei = 1'b1; tick();
        check("R7 bit cleared", outv(), 0);
        // R7: acknowledge without a request has no effect
        irq_ack = 1'b1; tick();
        src_pulse = 8'h20; tick();
        check("R7 stray ack", outv(), 16 + 5);
        // R9: pulse beats a pending-register write
        wr(2'd0, 16'h0000); src_pulse = 8'h04; tick();
        check("R9 pulse vs write", outv(), 16 + 2);
        // R9: pulse beats acknowledge of the same source
        irq_ack = 1'b1; src_pulse = 8'h04; tick();
        check("R9 ack off", outv(), 0);
        cmd_iret = 1'b1; tick();
        check("R9 R10 iret", outv(), 16 + 2);
        // R8: pending load
        wr(2'd0, 16'h0030); tick();
        check("R8 load", outv(), 16 + 4);
        wr(2'd3, 16'h0001); tick();
        check("R8 addr3 ignored", outv(), 16 + 4);
        // R11 / R10: enable clear and set events
        cmd_di = 1'b1; tick();
        check("R11 di", outv(), 0);
        cmd_ei = 1'b1; tick();
        check("R10 ei", outv(), 16 + 4);
        wr(2'd2, 16'h0000); tick();
        check("R11 ctrl 0", outv(), 0);
        wr(2'd2, 16'h0001); tick();
        check("R10 ctrl 1", outv(), 16 + 4);
        for (int t = 0; t < NTRAP; t++) begin
            trap_in = 4'(1 << t); tick();
            check("R11 trap", outv(), 0);
            cmd_ei = 1'b1; tick();
            check("R10 re-enable", outv(), 16 + 4);
        end
        cmd_ei = 1'b1; cmd_di = 1'b1; tick();
        check("R11 clear beats set", outv(), 0);
        wr(2'd2, 16'h0001); trap_in = 4'h1; tick();
        check("R11 trap beats write", outv(), 0);
        // R12: pending while disabled is hidden, then shown
        src_pulse = 8'h01; tick();
        check("R12 disabled", outv(), 0);
        cmd_ei = 1'b1; tick();
        check("R12 enabled", outv(), 16 + 0);
        // R3: code 00 removes source 0
        wr(2'd1, 16'h5554); tick();
        check("R3 code 00", outv(), 16 + 4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule